// File: doc/BRIEF.md
# Check-Bit Protected Program Scratchpad Controller

This controller sits in front of a program scratchpad RAM. Each 16-bit half-word is stored with six check bits, which together form a single-error-correct, double-error-detect code. The block has two ports. A bus port takes reads and writes of byte, half-word or word size. A fetch port reads one 32-bit word per request and returns, for each of its two half-words, a flag that marks an uncorrectable error. Single-bit errors are corrected in the data that is returned, with no report. Uncorrectable errors are reported only while the protection enable input is high.

Half-word and word writes compute the check bits from the write data and store data and check bits together. Byte writes cannot do this, because the check bits cover the whole half-word. A byte write therefore reads the containing half-word, corrects it, inserts the new byte, computes new check bits and writes the result back. This takes one extra cycle, and during that cycle the bus port holds its ready signal low.

A bus read that hits an uncorrectable half-word ends with a bus error response. The read phase of a byte merge is treated the same way. One cycle later the block also pulses a separate system error output, so that a system controller can raise a non-maskable interrupt even when the CPU was not the bus master.

Top module: `spram_ecc_ctrl`

## Requirements
- R1: A word write stores `bus_wdata[15:0]` in half-word lane 0 and `bus_wdata[31:16]` in lane 1, each lane with its own freshly computed check bits. A later read returns the same values with no error.
- R2: A half-word or word write is accepted in one cycle. `bus_done` is high in the cycle after acceptance, `bus_err` is low, and `bus_ready` stays high.
- R3: A bus read returns the whole 32-bit word on `bus_rdata`, with `bus_done` high, in the cycle after acceptance. A single-bit error in either lane is corrected in the returned data and raises no error.
- R4: With `prot_en` high, `bus_err` is raised together with `bus_done` only when a requested half-word holds an uncorrectable error. A word access requests both lanes. A half-word or byte access requests lane `bus_addr[1]` only.
- R5: `nmi_req` is a one-cycle pulse, raised in the cycle after each cycle in which `bus_err` is high.
- R6: A byte write replaces byte `bus_addr[0]` (1 = upper byte) of lane `bus_addr[1]` with `bus_wdata[8*bus_addr[1:0] +: 8]`. The other byte of that lane is preserved. `bus_ready` is low for exactly the one cycle after acceptance, and `bus_done` is high in that same cycle.
- R7: When the read phase of a byte write finds a single-bit error, the corrected half-word is used as the merge base. The stored result then reads back without error.
- R8: When the read phase of a byte write finds an uncorrectable error and `prot_en` is high, the write-back is suppressed and `bus_err` and `nmi_req` behave as they do for a read. A later read of that half-word still reports the error.
- R9: A fetch request returns, in the next cycle, `fetch_valid`, the corrected word on `fetch_data`, and `fetch_uerr[i]` high when half-word `i` holds an uncorrectable error.
- R10: While `prot_en` is low, uncorrectable errors are ignored: `bus_err`, `nmi_req` and `fetch_uerr` all stay low.
- R11: For word accesses the low two address bits are ignored. For half-word accesses `bus_addr[0]` is ignored. `bus_size` encodes 0 as byte, 1 as half-word and 2 as word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prot_en | input | 1 | Enables uncorrectable-error reporting |
| bus_req | input | 1 | Bus request valid |
| bus_we | input | 1 | Bus request is a write |
| bus_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| bus_addr | input | AW+2 | Byte address |
| bus_wdata | input | 32 | Write data on natural byte lanes |
| bus_ready | output | 1 | Request can be accepted this cycle |
| bus_done | output | 1 | Response cycle for an accepted request |
| bus_err | output | 1 | Bus error response, valid with bus_done |
| bus_rdata | output | 32 | Corrected read data, valid with bus_done |
| nmi_req | output | 1 | System error pulse following a bus error |
| fetch_req | input | 1 | Fetch read request |
| fetch_addr | input | AW | Fetch word address |
| fetch_valid | output | 1 | Fetch response valid |
| fetch_data | output | 32 | Corrected fetch word |
| fetch_uerr | output | 2 | Per-half-word uncorrectable-error flags |

## Verification
A wrong merge state shows up at the ports within two cycles. Either `bus_ready` fails to return high, or it drops when no byte write was accepted, or the neighbouring byte of the merged lane comes back changed on the next read. A corrupted check-bit computation is visible at the first read of the affected half-word: the read returns corrected data that differs from what was written, or reports an error where none was injected. A wrong lane mask shows as a bus error on a half-word read of the clean lane next to a corrupted one. It can also show as a missing error, and in either case `nmi_req` is wrong one cycle later.

// File: rtl/spram_ecc_pkg.sv
package spram_ecc_pkg;

  localparam int HW_W  = 16;
  localparam int CK_W  = 6;
  localparam int RAW_W = HW_W + CK_W;
  localparam int LANES = 2;
  localparam int BUS_W = HW_W * LANES;
  localparam int CW_N  = 21;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef enum logic {ST_IDLE, ST_MERGE} ctl_state_e;

  typedef struct packed {
    logic [HW_W-1:0] data;
    logic            uerr;
  } dec_res_t;

  // Places data bits at the non-power-of-two positions 3,5,6,7,9,... of a 21-bit Hamming word
  function automatic logic [CW_N-1:0] ecc_spread(input logic [HW_W-1:0] d);
    logic [CW_N-1:0] cw;
    int k;
    cw = '0;
    k = 0;
    for (int p = 1; p <= CW_N; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p-1] = d[k];
        k++;
      end
    end
    return cw;
  endfunction

  function automatic logic [CK_W-1:0] ecc_gen(input logic [HW_W-1:0] d);
    logic [CW_N-1:0] cw;
    logic [CK_W-1:0] c;
    cw = ecc_spread(d);
    c = '0;
    for (int i = 0; i < CK_W - 1; i++) begin
      for (int p = 1; p <= CW_N; p++) begin
        if ((((p >> i) & 1) == 1) && ((p & (p - 1)) != 0)) c[i] = c[i] ^ cw[p-1];
      end
    end
    c[CK_W-1] = ^{d, c[CK_W-2:0]};
    return c;
  endfunction

  function automatic dec_res_t ecc_check(input logic [HW_W-1:0] d, input logic [CK_W-1:0] c);
    logic [CW_N-1:0] cw;
    logic [4:0]      syn;
    logic            ovr;
    dec_res_t        r;
    int              k;
    cw = ecc_spread(d);
    for (int i = 0; i < CK_W - 1; i++) begin
      syn[i] = c[i];
      for (int p = 1; p <= CW_N; p++) begin
        if ((((p >> i) & 1) == 1) && ((p & (p - 1)) != 0)) syn[i] = syn[i] ^ cw[p-1];
      end
    end
    ovr    = ^{d, c};
    r.data = d;
    r.uerr = 1'b0;
    if (ovr) begin
      if (int'(syn) > CW_N) begin
        r.uerr = 1'b1;
      end else if ((syn & (syn - 5'd1)) != 5'd0) begin
        k = 0;
        for (int p = 1; p <= CW_N; p++) begin
          if ((p & (p - 1)) != 0) begin
            if (p == int'(syn)) r.data[k] = ~r.data[k];
            k++;
          end
        end
      end
    end else if (syn != 5'd0) begin
      r.uerr = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/spram_ram.sv
module spram_ram
  import spram_ecc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic                        clk,
  input  logic                        a_en,
  input  logic [LANES-1:0]            a_we,
  input  logic [AW-1:0]               a_addr,
  input  logic [LANES-1:0][RAW_W-1:0] a_wdata,
  output logic [LANES-1:0][RAW_W-1:0] a_rdata,
  input  logic                        b_en,
  input  logic [AW-1:0]               b_addr,
  output logic [LANES-1:0][RAW_W-1:0] b_rdata
);

  localparam int DEPTH = 1 << AW;

  logic [RAW_W-1:0] mem [DEPTH][LANES];

  always_ff @(posedge clk) begin
    if (a_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (a_we[l]) mem[a_addr][l] <= a_wdata[l];
        a_rdata[l] <= mem[a_addr][l];
      end
    end
    if (b_en) begin
      for (int l = 0; l < LANES; l++) b_rdata[l] <= mem[b_addr][l];
    end
  end

endmodule

// File: rtl/spram_lane_dec.sv
module spram_lane_dec
  import spram_ecc_pkg::*;
(
  input  logic [RAW_W-1:0] raw,
  input  logic             chk_en,
  output logic [HW_W-1:0]  data,
  output logic             uerr
);

  dec_res_t res;

  always_comb begin
    res  = ecc_check(raw[HW_W-1:0], raw[RAW_W-1:HW_W]);
    data = res.data;
    uerr = chk_en & res.uerr;
  end

endmodule

// File: rtl/spram_ecc_ctrl.sv
module spram_ecc_ctrl
  import spram_ecc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prot_en,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [1:0]    bus_size,
  input  logic [AW+1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic          bus_ready,
  output logic          bus_done,
  output logic          bus_err,
  output logic [31:0]   bus_rdata,
  output logic          nmi_req,
  input  logic          fetch_req,
  input  logic [AW-1:0] fetch_addr,
  output logic          fetch_valid,
  output logic [31:0]   fetch_data,
  output logic [1:0]    fetch_uerr
);

  ctl_state_e state;
  logic            r_read, r_wr;
  logic [AW-1:0]   h_idx;
  logic [LANES-1:0] h_mask;
  logic            h_lane, h_byte;
  logic [7:0]      h_bdata;
  logic            nmi_q, f_valid_q;

  logic [AW-1:0]    req_idx;
  logic             req_lane, is_byte;
  logic [LANES-1:0] req_mask;
  logic             wr_full, byte_start, in_merge;

  // events exposed for the checker
  logic ev_accept, ev_merge_wb, ev_bus_uerr;

  logic                        a_en;
  logic [LANES-1:0]            a_we;
  logic [AW-1:0]               a_addr;
  logic [LANES-1:0][RAW_W-1:0] a_wdata, a_rdata, b_rdata, enc_raw;
  logic [LANES-1:0][HW_W-1:0]  bdec_data, fdec_data;
  logic [LANES-1:0]            bdec_uerr, fdec_uerr;

  logic [HW_W-1:0]  mrg_base, mrg_data;
  logic [RAW_W-1:0] mrg_raw;
  logic             lane_uerr_any, merge_abort;

  assign req_idx  = bus_addr[AW+1:2];
  assign req_lane = bus_addr[1];
  assign is_byte  = (bus_size == SZ_BYTE);
  assign req_mask = bus_size[1] ? {LANES{1'b1}} : (LANES'(1) << req_lane);

  assign bus_ready  = (state == ST_IDLE);
  assign in_merge   = (state == ST_MERGE);
  assign ev_accept  = bus_req & bus_ready;
  assign wr_full    = ev_accept & bus_we & ~is_byte;
  assign byte_start = ev_accept & bus_we & is_byte;

  genvar gl;
  generate
    for (gl = 0; gl < LANES; gl++) begin : g_lane
      assign enc_raw[gl] = {ecc_gen(bus_wdata[gl*HW_W +: HW_W]), bus_wdata[gl*HW_W +: HW_W]};

      spram_lane_dec u_bdec (
        .raw    (a_rdata[gl]),
        .chk_en (prot_en),
        .data   (bdec_data[gl]),
        .uerr   (bdec_uerr[gl])
      );

      spram_lane_dec u_fdec (
        .raw    (b_rdata[gl]),
        .chk_en (prot_en),
        .data   (fdec_data[gl]),
        .uerr   (fdec_uerr[gl])
      );
    end
  endgenerate

  // byte merge on top of the corrected half-word
  always_comb begin
    mrg_base = bdec_data[h_lane];
    mrg_data = h_byte ? {h_bdata, mrg_base[7:0]} : {mrg_base[15:8], h_bdata};
    mrg_raw  = {ecc_gen(mrg_data), mrg_data};
  end

  assign lane_uerr_any = |(bdec_uerr & h_mask);
  assign merge_abort   = in_merge & lane_uerr_any;
  assign ev_merge_wb   = in_merge & ~merge_abort;
  assign ev_bus_uerr   = (r_read | in_merge) & lane_uerr_any;

  always_comb begin
    a_en    = ev_accept | in_merge;
    a_addr  = in_merge ? h_idx : req_idx;
    a_we    = '0;
    a_wdata = enc_raw;
    if (in_merge) begin
      a_wdata = {LANES{mrg_raw}};
      if (!merge_abort) a_we = LANES'(1) << h_lane;
    end else if (wr_full) begin
      a_we = req_mask;
    end
  end

  spram_ram #(.AW(AW)) u_ram (
    .clk     (clk),
    .a_en    (a_en),
    .a_we    (a_we),
    .a_addr  (a_addr),
    .a_wdata (a_wdata),
    .a_rdata (a_rdata),
    .b_en    (fetch_req),
    .b_addr  (fetch_addr),
    .b_rdata (b_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      r_read    <= 1'b0;
      r_wr      <= 1'b0;
      h_idx     <= '0;
      h_mask    <= '0;
      h_lane    <= 1'b0;
      h_byte    <= 1'b0;
      h_bdata   <= '0;
      nmi_q     <= 1'b0;
      f_valid_q <= 1'b0;
    end else begin
      r_read    <= ev_accept & ~bus_we;
      r_wr      <= wr_full;
      nmi_q     <= ev_bus_uerr;
      f_valid_q <= fetch_req;
      if (ev_accept) begin
        h_idx   <= req_idx;
        h_mask  <= req_mask;
        h_lane  <= req_lane;
        h_byte  <= bus_addr[0];
        h_bdata <= bus_wdata[8*bus_addr[1:0] +: 8];
      end
      case (state)
        ST_IDLE:  if (byte_start) state <= ST_MERGE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign bus_done    = r_read | r_wr | in_merge;
  assign bus_err     = ev_bus_uerr;
  assign bus_rdata   = bdec_data;
  assign nmi_req     = nmi_q;
  assign fetch_valid = f_valid_q;
  assign fetch_data  = fdec_data;
  assign fetch_uerr  = fdec_uerr;

endmodule

// File: rtl/spram_ecc_chk.sv
module spram_ecc_chk #(
  parameter int AW = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       prot_en,
  input logic       bus_we,
  input logic [1:0] bus_size,
  input logic       bus_ready,
  input logic       bus_done,
  input logic       bus_err,
  input logic       nmi_req,
  input logic       fetch_req,
  input logic       fetch_valid,
  input logic [1:0] fetch_uerr,
  input logic       ev_accept,
  input logic       ev_merge_wb
);

  // R2
  full_write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && bus_we && bus_size != 2'd0 |=> bus_done && !bus_err && bus_ready);

  // R3
  read_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && !bus_we |=> bus_done);

  // R6
  merge_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && bus_we && bus_size == 2'd0 |=> !bus_ready && bus_done ##1 bus_ready);

  // R6
  ready_low_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |-> $past(ev_accept && bus_we && bus_size == 2'd0));

  // R4
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_done);

  // R5
  nmi_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> nmi_req);

  // R5
  nmi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> $past(bus_err));

  // R8
  no_wb_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_merge_wb |-> !bus_err);

  // R9
  fetch_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> fetch_valid);

  // R10
  prot_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_en |-> !bus_err && fetch_uerr == 2'b00);

endmodule

bind spram_ecc_ctrl spram_ecc_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .prot_en     (prot_en),
  .bus_we      (bus_we),
  .bus_size    (bus_size),
  .bus_ready   (bus_ready),
  .bus_done    (bus_done),
  .bus_err     (bus_err),
  .nmi_req     (nmi_req),
  .fetch_req   (fetch_req),
  .fetch_valid (fetch_valid),
  .fetch_uerr  (fetch_uerr),
  .ev_accept   (ev_accept),
  .ev_merge_wb (ev_merge_wb)
);

// File: tb/tb_spram_ecc_ctrl.sv
module tb_spram_ecc_ctrl;

  localparam int AW = 8;
  localparam int NHW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          prot_en = 1'b1;
  logic          bus_req = 1'b0;
  logic          bus_we = 1'b0;
  logic [1:0]    bus_size = 2'd0;
  logic [AW+1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_ready, bus_done, bus_err, nmi_req;
  logic [31:0]   bus_rdata;
  logic          fetch_req = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          fetch_valid;
  logic [31:0]   fetch_data;
  logic [1:0]    fetch_uerr;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  logic [15:0] mdl [NHW];
  int          st  [NHW];   // 0 clean, 1 single flip, 2 double flip

  spram_ecc_ctrl #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .prot_en(prot_en),
    .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_done(bus_done), .bus_err(bus_err),
    .bus_rdata(bus_rdata), .nmi_req(nmi_req), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data), .fetch_uerr(fetch_uerr)
  );

  always #4 clk = ~clk;

  task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // check bits: parity groups over data bits placed at non-power-of-two positions
  function automatic logic [5:0] b_ecc(input logic [15:0] d);
    logic [5:0] c = '0;
    int pos = 3;
    for (int k = 0; k < 16; k++) begin
      while ((pos & (pos - 1)) == 0) pos++;
      for (int i = 0; i < 5; i++) if (pos[i]) c[i] ^= d[k];
      pos++;
    end
    c[5] = (^d) ^ (^c[4:0]);
    return c;
  endfunction

  task automatic inject(input int w, input int l, input logic [15:0] d, input int nflip);
    logic [21:0] raw;
    int b1, b2;
    raw = {b_ecc(d), d};
    b1 = int'($urandom % 22);
    raw[b1] = ~raw[b1];
    if (nflip == 2) begin
      b2 = (b1 + 1 + int'($urandom % 21)) % 22;
      raw[b2] = ~raw[b2];
    end
    dut.u_ram.mem[w][l] = raw;
    mdl[w*2+l] = d;
    st[w*2+l] = nflip;
  endtask

  task automatic bus_op(input logic we, input logic [1:0] sz, input logic [9:0] addr,
                        input logic [31:0] wd, input string tag);
    int w, l, hw;
    logic [1:0] mask;
    logic experr, exprdy;
    logic d_done, d_err, d_rdy, d_nmi, d_rdy2;
    logic [31:0] d_rd;
    w = int'(addr[9:2]); l = int'(addr[1]); hw = w*2 + l;
    mask = sz[1] ? 2'b11 : (2'b01 << l);
    experr = 1'b0;
    exprdy = 1'b1;
    if (!we) begin
      for (int i = 0; i < 2; i++) if (mask[i] && st[w*2+i] == 2) experr = prot_en;
    end else if (sz == 2'd0) begin
      exprdy = 1'b0;
      experr = prot_en && st[hw] == 2;
    end
    @(negedge clk);
    while (!bus_ready) @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_size = sz; bus_addr = addr; bus_wdata = wd;
    @(negedge clk);
    d_done = bus_done; d_err = bus_err; d_rd = bus_rdata; d_rdy = bus_ready;
    bus_req = 1'b0;
    @(negedge clk);
    d_nmi = nmi_req; d_rdy2 = bus_ready;
    ck({tag, " done"}, 32'(d_done), 32'd1);
    ck({tag, " err"}, 32'(d_err), 32'(experr));
    ck({tag, " nmi"}, 32'(d_nmi), 32'(experr));
    ck({tag, " ready"}, 32'(d_rdy), 32'(exprdy));
    ck({tag, " ready after"}, 32'(d_rdy2), 32'd1);
    if (!we) begin
      for (int i = 0; i < 2; i++)
        if (st[w*2+i] != 2) ck({tag, " rdata"}, 32'(d_rd[16*i +: 16]), 32'(mdl[w*2+i]));
    end else if (sz != 2'd0) begin
      for (int i = 0; i < 2; i++)
        if (mask[i]) begin mdl[w*2+i] = wd[16*i +: 16]; st[w*2+i] = 0; end
    end else if (st[hw] != 2) begin
      if (addr[0]) mdl[hw][15:8] = wd[8*addr[1:0] +: 8];
      else         mdl[hw][7:0]  = wd[8*addr[1:0] +: 8];
      st[hw] = 0;
    end
  endtask

  task automatic fetch_op(input int w, input string tag);
    logic [1:0] eu;
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = AW'(w);
    @(negedge clk);
    fetch_req = 1'b0;
    for (int i = 0; i < 2; i++) eu[i] = prot_en && st[w*2+i] == 2;
    ck({tag, " fvalid"}, 32'(fetch_valid), 32'd1);
    ck({tag, " fuerr"}, 32'(fetch_uerr), 32'(eu));
    for (int i = 0; i < 2; i++)
      if (st[w*2+i] != 2) ck({tag, " fdata"}, 32'(fetch_data[16*i +: 16]), 32'(mdl[w*2+i]));
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = int'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    ck("reset ready", 32'(bus_ready), 32'd1);
    ck("reset done", 32'(bus_done), 32'd0);
    ck("reset nmi", 32'(nmi_req), 32'd0);
    ck("reset fvalid", 32'(fetch_valid), 32'd0);
    rst_n = 1'b1;

    // R1 R2: fill region with word writes, read back
    for (int w = 0; w < NHW/2; w++) bus_op(1'b1, 2'd2, 10'(w*4), $urandom, "R1 fill");
    for (int w = 0; w < NHW/2; w++) bus_op(1'b0, 2'd2, 10'(w*4), 32'd0, "R1 readback");
    // R11: ignored low address bits
    bus_op(1'b1, 2'd2, 10'(2*4+3), 32'hCAFE_F00D, "R11 word addr");
    bus_op(1'b1, 2'd1, 10'(2*4+3), 32'h1234_BEEF, "R11 half addr");
    bus_op(1'b0, 2'd1, 10'(2*4+1), 32'd0, "R11 read");
    // R3: single-bit correction
    inject(3, 0, 16'hA5C3, 1);
    inject(3, 1, 16'h0F0F, 1);
    bus_op(1'b0, 2'd2, 10'(3*4), 32'd0, "R3 single");
    // R4 R5: double in lane 1, only lane-1 requests flag
    inject(4, 1, 16'h7777, 2);
    bus_op(1'b0, 2'd1, 10'(4*4), 32'd0, "R4 clean lane");
    bus_op(1'b0, 2'd0, 10'(4*4+1), 32'd0, "R4 byte clean lane");
    bus_op(1'b0, 2'd2, 10'(4*4), 32'd0, "R5 word err");
    bus_op(1'b0, 2'd1, 10'(4*4+2), 32'd0, "R4 half err");
    // R6: byte write merge
    bus_op(1'b1, 2'd0, 10'(5*4+1), 32'h0000_AB00, "R6 byte1");
    bus_op(1'b1, 2'd0, 10'(5*4+2), 32'h00CD_0000, "R6 byte2");
    bus_op(1'b0, 2'd2, 10'(5*4), 32'd0, "R6 readback");
    // R7: merge with corrected base
    inject(6, 1, 16'h3C5A, 1);
    bus_op(1'b1, 2'd0, 10'(6*4+3), 32'h9900_0000, "R7 merge");
    bus_op(1'b0, 2'd2, 10'(6*4), 32'd0, "R7 readback");
    // R8: merge abort on double
    inject(7, 0, 16'h1111, 2);
    bus_op(1'b1, 2'd0, 10'(7*4), 32'h0000_0055, "R8 merge err");
    bus_op(1'b0, 2'd1, 10'(7*4), 32'd0, "R8 still bad");
    // R9: fetch flags
    fetch_op(3, "R9 fetch single");
    fetch_op(4, "R9 fetch double");
    fetch_op(7, "R9 fetch lane0");
    fetch_op(5, "R9 fetch clean");
    // R10: protection disabled
    prot_en = 1'b0;
    bus_op(1'b0, 2'd2, 10'(4*4), 32'd0, "R10 read");
    bus_op(1'b0, 2'd1, 10'(7*4), 32'd0, "R10 half");
    fetch_op(4, "R10 fetch");
    prot_en = 1'b1;
    bus_op(1'b1, 2'd2, 10'(4*4), $urandom, "R2 repair");
    bus_op(1'b1, 2'd2, 10'(7*4), $urandom, "R2 repair");

    // random mix
    for (int n = 0; n < 500; n++) begin
      int w, r, op;
      logic [1:0] sz;
      logic [9:0] a;
      w = int'($urandom % (NHW/2));
      r = int'($urandom % 100);
      if (r < 8) inject(w, int'($urandom % 2), 16'($urandom), 1);
      else if (r < 12) inject(w, int'($urandom % 2), 16'($urandom), 2);
      op = int'($urandom % 7);
      sz = 2'($urandom % 3);
      a = 10'(w*4) | 10'($urandom % 4);
      case (op)
        0, 1:    bus_op(1'b0, sz, a, 32'd0, "R3 rnd read");
        2:       bus_op(1'b1, 2'd2, a, $urandom, "R1 rnd word");
        3:       bus_op(1'b1, 2'd1, a, $urandom, "R11 rnd half");
        4, 5:    bus_op(1'b1, 2'd0, a, $urandom, "R6 rnd byte");
        default: fetch_op(w, "R9 rnd fetch");
      endcase
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule